// File: doc/BRIEF.md
# Colour-Sequenced Palette and Cursor Address Counter

This block generates the address for host accesses to the colour palette, the cursor-colour and overscan registers, and a 64x64x2 cursor pattern RAM. It holds one 10-bit auto-incrementing counter. The low byte is written through the address register. The top two bits are written through bits 1:0 of an indirectly reached command register. Reading that register back returns the counter's live top bits, so software can follow the counter as it advances.

Palette-type locations hold three colour bytes each. For these accesses the block steps a component index through red, green and blue. When blue has been accessed, it moves the low address byte on by one. Each cursor RAM data access moves the full 10-bit counter on by one. The block also latches whether the last address write was in write mode or read mode.

The host presents one access per cycle on `acc_i`. The access carries a 3-bit select code, a read/write flag and write data. The RAM arrays are outside this block.

Top module: `cursor_addr_seq`

## Requirements
- R1: After reset `addr_o` is 0, `comp_o` is 0 (red), `rd_cycle_o` is 0, and reading select 6 returns 0x00.
- R2: A write to select 0 or select 3 loads `wdata_i` into `addr_o[7:0]` and sets `comp_o` to 0. `addr_o[9:8]` keeps its value.
- R3: A write to select 6 (command register 3) loads `wdata_i[1:0]` into `addr_o[9:8]` and keeps `wdata_i[7:2]`. A read of select 6 returns the kept bits in 7:2.
- R4: Bits 1:0 of a select 6 read always equal the current `addr_o[9:8]`, including after the counter has incremented across a 256 boundary.
- R5: A read or write to select 1, 2 or 4 (palette, cursor colour, overscan) steps `comp_o` from 0 (red) to 1 (green) to 2 (blue) and back to 0. On the step from 2 to 0, `addr_o[7:0]` increments and wraps from 255 to 0 without changing `addr_o[9:8]`.
- R6: A read or write to select 5 (cursor RAM data) increments the 10-bit `addr_o`, wraps it from 1023 to 0, and leaves `comp_o` unchanged.
- R7: A write to select 0 clears `rd_cycle_o`, and a write to select 3 sets it. No other access changes it.
- R8: A cycle without `acc_i`, and a read of select 0, 3 or 6, leaves `addr_o` and `comp_o` unchanged.
- R9: `rdata_o` returns `addr_o[7:0]` for select 0 or 3, the command register 3 value for select 6, and 0x00 for every other select.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| acc_i | input | 1 | Host access strobe, one access per cycle |
| wr_i | input | 1 | 1 = write, 0 = read |
| sel_i | input | 3 | Register select code |
| wdata_i | input | 8 | Host write data |
| rdata_o | output | 8 | Read-back value for `sel_i` |
| addr_o | output | 10 | RAM / palette address |
| comp_o | output | 2 | Colour component index (0 red, 1 green, 2 blue) |
| rd_cycle_o | output | 1 | Latched cycle type of the last address write |

## Verification
The bench builds the block with its default parameters: a 10-bit counter whose low part is 8 bits, and 8-bit host data. With these values the counter's two wrap points are within a few accesses of a loaded address. The low byte wraps from 255 to 0 during palette stepping, and the full counter wraps from 1023 to 0 during cursor RAM access. The same values leave room for the carry from 0x1FF into the top bits, which then shows up in the command register read-back.

// File: rtl/cursor_addr_pkg.sv
package cursor_addr_pkg;
  typedef enum logic [2:0] {
    SEL_ADDR_WR = 3'd0,
    SEL_PAL     = 3'd1,
    SEL_CCOL    = 3'd2,
    SEL_ADDR_RD = 3'd3,
    SEL_OVS     = 3'd4,
    SEL_CRAM    = 3'd5,
    SEL_CMD3    = 3'd6,
    SEL_RSVD    = 3'd7
  } sel_e;

  typedef enum logic [1:0] {
    COMP_R = 2'd0,
    COMP_G = 2'd1,
    COMP_B = 2'd2
  } comp_e;
endpackage

// File: rtl/comp_seq.sv
module comp_seq
  import cursor_addr_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       clr_i,
  input  logic       step_i,
  output logic [1:0] comp_o,
  output logic       wrap_o
);
  comp_e comp_q, comp_d;

  assign wrap_o = step_i && (comp_q == COMP_B);

  always_comb begin
    comp_d = comp_q;
    if (clr_i) comp_d = COMP_R;
    else if (step_i) begin
      unique case (comp_q)
        COMP_R:  comp_d = COMP_G;
        COMP_G:  comp_d = COMP_B;
        default: comp_d = COMP_R;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) comp_q <= COMP_R;
    else         comp_q <= comp_d;
  end

  assign comp_o = comp_q;
endmodule

// File: rtl/addr_ctr.sv
module addr_ctr #(
  parameter int ADDR_W = 10,
  parameter int LO_W   = 8
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   ld_lo_i,
  input  logic [LO_W-1:0]        lo_i,
  input  logic                   ld_hi_i,
  input  logic [ADDR_W-LO_W-1:0] hi_i,
  input  logic                   inc_lo_i,
  input  logic                   inc_all_i,
  output logic [ADDR_W-1:0]      addr_o
);
  localparam int HI_W = ADDR_W - LO_W;

  logic [LO_W-1:0] lo_q, lo_d;
  logic [HI_W-1:0] hi_q, hi_d;

  always_comb begin
    lo_d = lo_q;
    hi_d = hi_q;
    if (inc_all_i) begin
      {hi_d, lo_d} = {hi_q, lo_q} + ADDR_W'(1);
    end else begin
      if (inc_lo_i) lo_d = lo_q + LO_W'(1);  // palette stepping stays in the low byte
      if (ld_lo_i)  lo_d = lo_i;
      if (ld_hi_i)  hi_d = hi_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lo_q <= '0;
      hi_q <= '0;
    end else begin
      lo_q <= lo_d;
      hi_q <= hi_d;
    end
  end

  assign addr_o = {hi_q, lo_q};
endmodule

// File: rtl/cursor_addr_seq.sv
module cursor_addr_seq
  import cursor_addr_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int LO_W   = 8,
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              acc_i,
  input  logic              wr_i,
  input  logic [2:0]        sel_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [1:0]        comp_o,
  output logic              rd_cycle_o
);
  localparam int HI_W = ADDR_W - LO_W;

  sel_e sel;
  assign sel = sel_e'(sel_i);

  logic wr_addr, wr_cmd3, pal_acc, cram_acc, pal_wrap;
  logic [DATA_W-1:0] cmd3_q;
  logic rd_cycle_q;

  assign wr_addr  = acc_i && wr_i && (sel == SEL_ADDR_WR || sel == SEL_ADDR_RD);
  assign wr_cmd3  = acc_i && wr_i && (sel == SEL_CMD3);
  assign pal_acc  = acc_i && (sel == SEL_PAL || sel == SEL_CCOL || sel == SEL_OVS);
  assign cram_acc = acc_i && (sel == SEL_CRAM);

  comp_seq i_comp (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (wr_addr),
    .step_i (pal_acc),
    .comp_o (comp_o),
    .wrap_o (pal_wrap)
  );

  addr_ctr #(.ADDR_W(ADDR_W), .LO_W(LO_W)) i_ctr (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .ld_lo_i   (wr_addr),
    .lo_i      (wdata_i[LO_W-1:0]),
    .ld_hi_i   (wr_cmd3),
    .hi_i      (wdata_i[HI_W-1:0]),
    .inc_lo_i  (pal_wrap),
    .inc_all_i (cram_acc),
    .addr_o    (addr_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmd3_q     <= '0;
      rd_cycle_q <= 1'b0;
    end else begin
      if (wr_cmd3) cmd3_q <= wdata_i;
      if (wr_addr) rd_cycle_q <= (sel == SEL_ADDR_RD);
    end
  end

  assign rd_cycle_o = rd_cycle_q;

  always_comb begin
    rdata_o = '0;
    unique case (sel)
      SEL_ADDR_WR, SEL_ADDR_RD: rdata_o = DATA_W'(addr_o[LO_W-1:0]);
      SEL_CMD3: rdata_o = {cmd3_q[DATA_W-1:HI_W], addr_o[ADDR_W-1:LO_W]};  // live top bits
      default:  rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/cursor_addr_chk.sv
module cursor_addr_chk #(
  parameter int ADDR_W = 10,
  parameter int LO_W   = 8,
  parameter int DATA_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              acc_i,
  input logic              wr_i,
  input logic [2:0]        sel_i,
  input logic [DATA_W-1:0] wdata_i,
  input logic [DATA_W-1:0] rdata_o,
  input logic [ADDR_W-1:0] addr_o,
  input logic [1:0]        comp_o,
  input logic              rd_cycle_o
);
  localparam int HI_W = ADDR_W - LO_W;

  a_r5_comp_legal: assert property (@(posedge clk_i) disable iff (!rst_ni)
    comp_o != 2'd3);

  a_r2_addr_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_i && wr_i && (sel_i == 3'd0 || sel_i == 3'd3)) |=>
      (addr_o[LO_W-1:0] == $past(wdata_i[LO_W-1:0])) && (comp_o == 2'd0) &&
      (addr_o[ADDR_W-1:LO_W] == $past(addr_o[ADDR_W-1:LO_W])));

  a_r3_hi_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_i && wr_i && sel_i == 3'd6) |=> addr_o[ADDR_W-1:LO_W] == $past(wdata_i[HI_W-1:0]));

  a_r6_cram_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_i && sel_i == 3'd5) |=> (addr_o == $past(addr_o) + ADDR_W'(1)) && $stable(comp_o));

  a_r7_rd_mode: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_i && wr_i && sel_i == 3'd3) |=> rd_cycle_o);

  a_r8_idle_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !acc_i |=> $stable(addr_o) && $stable(comp_o));

  a_r4_cmd3_live: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_i == 3'd6) |-> rdata_o[HI_W-1:0] == addr_o[ADDR_W-1:LO_W]);
endmodule

bind cursor_addr_seq cursor_addr_chk #(.ADDR_W(ADDR_W), .LO_W(LO_W), .DATA_W(DATA_W)) i_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .acc_i      (acc_i),
  .wr_i       (wr_i),
  .sel_i      (sel_i),
  .wdata_i    (wdata_i),
  .rdata_o    (rdata_o),
  .addr_o     (addr_o),
  .comp_o     (comp_o),
  .rd_cycle_o (rd_cycle_o)
);

// File: tb/test_cursor_addr_seq.sv
module test_cursor_addr_seq;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 16;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       acc_i = 1'b0;
  logic       wr_i = 1'b0;
  logic [2:0] sel_i = 3'd7;
  logic [7:0] wdata_i = 8'h00;
  logic [7:0] rdata_o;
  logic [9:0] addr_o;
  logic [1:0] comp_o;
  logic       rd_cycle_o;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  cursor_addr_seq i_cursor_addr_seq (
    .clk_i(clk_i), .rst_ni(rst_ni), .acc_i(acc_i), .wr_i(wr_i), .sel_i(sel_i),
    .wdata_i(wdata_i), .rdata_o(rdata_o), .addr_o(addr_o), .comp_o(comp_o),
    .rd_cycle_o(rd_cycle_o)
  );

  // {sel, wr, wdata, exp_addr, exp_comp, exp_rd_cycle}
  localparam logic [24:0] VEC [NVEC] = '{
    {3'd0, 1'b1, 8'h10, 10'h010, 2'd0, 1'b0},  // R2 R7
    {3'd1, 1'b1, 8'h00, 10'h010, 2'd1, 1'b0},  // R5
    {3'd2, 1'b1, 8'h00, 10'h010, 2'd2, 1'b0},  // R5
    {3'd4, 1'b0, 8'h00, 10'h011, 2'd0, 1'b0},  // R5
    {3'd6, 1'b1, 8'hA6, 10'h211, 2'd0, 1'b0},  // R3
    {3'd3, 1'b1, 8'hFF, 10'h2FF, 2'd0, 1'b1},  // R2 R7
    {3'd1, 1'b0, 8'h00, 10'h2FF, 2'd1, 1'b1},  // R5
    {3'd1, 1'b0, 8'h00, 10'h2FF, 2'd2, 1'b1},  // R5
    {3'd1, 1'b0, 8'h00, 10'h200, 2'd0, 1'b1},  // R5 low-byte wrap
    {3'd6, 1'b1, 8'h03, 10'h300, 2'd0, 1'b1},  // R3
    {3'd0, 1'b1, 8'hFE, 10'h3FE, 2'd0, 1'b0},  // R2 R7
    {3'd5, 1'b1, 8'h00, 10'h3FF, 2'd0, 1'b0},  // R6
    {3'd5, 1'b0, 8'h00, 10'h000, 2'd0, 1'b0},  // R6 wrap
    {3'd1, 1'b1, 8'h00, 10'h000, 2'd1, 1'b0},  // R5
    {3'd5, 1'b1, 8'h00, 10'h001, 2'd1, 1'b0},  // R6 comp held
    {3'd6, 1'b0, 8'h00, 10'h001, 2'd1, 1'b0}   // R8 read of cmd3
  };

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic access(logic [2:0] s, logic w, logic [7:0] d);
    @(negedge clk_i);
    acc_i = 1'b1; sel_i = s; wr_i = w; wdata_i = d;
    @(negedge clk_i);
    acc_i = 1'b0; wr_i = 1'b0;
  endtask

  task automatic peek(logic [2:0] s);
    sel_i = s;
    #1;
  endtask

  initial begin
    #(CLK_PERIOD*100000);
    if (!done) begin
      n_fail++; n_run++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (2) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk("R1 addr", 32'(addr_o), 0);
    chk("R1 comp", 32'(comp_o), 0);
    chk("R1 rd_cycle", 32'(rd_cycle_o), 0);
    peek(3'd6); chk("R1 cmd3", 32'(rdata_o), 0);

    for (int i = 0; i < NVEC; i++) begin
      access(VEC[i][24:22], VEC[i][21], VEC[i][20:13]);
      chk($sformatf("vec%0d addr", i), 32'(addr_o), 32'(VEC[i][12:3]));
      chk($sformatf("vec%0d comp", i), 32'(comp_o), 32'(VEC[i][2:1]));
      chk($sformatf("vec%0d R7 rd_cycle", i), 32'(rd_cycle_o), 32'(VEC[i][0]));
    end

    access(3'd6, 1'b1, 8'hA5);
    peek(3'd6); chk("R3 cmd3 readback", 32'(rdata_o), 32'hA5);
    access(3'd0, 1'b1, 8'hFF);
    peek(3'd0); chk("R9 addr readback", 32'(rdata_o), 32'hFF);
    access(3'd5, 1'b0, 8'h00);
    chk("R6 carry into top", 32'(addr_o), 32'h200);
    peek(3'd6); chk("R4 live top bits", 32'(rdata_o), 32'hA6);
    peek(3'd3); chk("R9 addr readback rd", 32'(rdata_o), 32'h00);
    peek(3'd1); chk("R9 other select", 32'(rdata_o), 32'h00);

    access(3'd0, 1'b0, 8'h55);
    access(3'd3, 1'b0, 8'h55);
    repeat (3) @(negedge clk_i);
    chk("R8 hold addr", 32'(addr_o), 32'h200);
    chk("R8 hold comp", 32'(comp_o), 0);
    chk("R7 reads keep mode", 32'(rd_cycle_o), 0);

    access(3'd3, 1'b1, 8'h07);
    access(3'd1, 1'b1, 8'h00);
    rst_ni = 1'b0;
    #1;
    chk("R1 async addr", 32'(addr_o), 0);
    chk("R1 async comp", 32'(comp_o), 0);
    chk("R1 async rd_cycle", 32'(rd_cycle_o), 0);
    peek(3'd6); chk("R1 cmd3 cleared", 32'(rdata_o), 0);
    @(negedge clk_i);
    rst_ni = 1'b1;

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule